// File: doc/BRIEF.md
# Boundary-Scan Data Register Chain

This block is the serial test register that sits at the edge of a chip, with one cell for each signal that crosses between the core and the pads. The chain joins the test data input to the test data output while a boundary test instruction is selected. A test access port controller drives three single-cycle strobes: capture, shift and update. Capture takes a parallel snapshot. Shift moves that snapshot out bit by bit while new test data moves in. Update copies the new data into a holding stage.

Cells `0` to `NUM_IN-1` watch input pins. Cells `NUM_IN` to `NUM_IN+NUM_OUT-1` sit on output pins, and only these cells have an update stage. In observe-only mode the output pins carry the core's values, so the chip keeps running normally while it is sampled. In drive mode the output pins carry the update-stage values instead, which lets opens and shorts between chips be found. The shift register moves data on rising edges of `tck`. The update stage and `tdo` change on falling edges, so the pins do not move while data is being shifted.

Top module: `bsr_chain`

## Requirements
- R1: An active-low `rst_n` clears the shift register, the update stage and `tdo` at once, without waiting for a clock edge. After reset, `pin_out` is 0 in drive mode and equals `core_out` in observe mode.
- R2: While `mode_extest` is 0 (observe mode), `pin_out` equals `core_out` at all times, including after an update.
- R3: While `mode_extest` is 1 (drive mode), `pin_out` equals the update stage. This holds immediately after the mode changes.
- R4: On a rising edge with `chain_sel` and `capture_en` high, cell i for i < NUM_IN loads `pin_in[i]`. Cell NUM_IN+j loads `pin_out[j]`, the value the pin is being driven with at that moment.
- R5: On a rising edge with `chain_sel` and `shift_en` high (and `capture_en` low), every cell takes the value of its neighbour toward the `tdi` end, and cell N-1 takes `tdi`. On each falling edge in a shift cycle, `tdo` takes cell 0, so captured bit k appears in shift cycle k.
- R6: On a falling edge with `chain_sel` and `update_en` high, the update stage loads cells NUM_IN..N-1. At no other time does it change, so `pin_out` holds steady while data is shifted.
- R7: While `chain_sel` is low, the capture, shift and update strobes have no effect: the shift contents, the update stage and `tdo` all stay the same.
- R8: If capture and shift are requested in the same cycle, capture takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chain_sel | input | 1 | A boundary test instruction is active |
| capture_en | input | 1 | Controller is in the data-capture state |
| shift_en | input | 1 | Controller is in the data-shift state |
| update_en | input | 1 | Controller is in the data-update state |
| mode_extest | input | 1 | 1: pins driven from the update stage; 0: pins follow the core |
| tdi | input | 1 | Serial test data in |
| core_out | input | NUM_OUT | Values the core wants on the output pins |
| pin_in | input | NUM_IN | Values seen at the input pins |
| pin_out | output | NUM_OUT | Values driven to the output pins |
| tdo | output | 1 | Serial test data out, changes on falling edges |

## Verification
Several rules are checked by the assertions on every clock edge:
- the pin multiplexing in both modes;
- the update stage holding still outside a selected update cycle;
- the update stage loading from the output cells;
- `tdo` taking cell 0 in shift cycles;
- the one-place shift;
- capture loading the input-pin values;
- the chain freezing while it is not selected.

Other behaviour can only be shown by the bench's scenarios. These are:
- full capture–shift–update sequences, in which the snapshot read out bit by bit must match the pin and core values it was taken from;
- capture winning over a simultaneous shift;
- the asynchronous clear in the middle of a test;
- pin values that do not move during long shifts in drive mode.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic {
    MODE_OBSERVE = 1'b0,
    MODE_DRIVE   = 1'b1
  } bsr_mode_e;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } bsr_ctl_t;

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_an
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_an = stage2_q;
endmodule

// File: rtl/bsr_ctl_gate.sv
module bsr_ctl_gate
  import bsr_pkg::*;
(
  input  logic     chain_sel,
  input  logic     capture_en,
  input  logic     shift_en,
  input  logic     update_en,
  output bsr_ctl_t ctl
);
  // Strobes count only while the chain is selected; capture beats shift (R8).
  always_comb begin
    ctl.capture = chain_sel & capture_en;
    ctl.shift   = chain_sel & shift_en & ~capture_en;
    ctl.update  = chain_sel & update_en;
  end
endmodule

// File: rtl/bsr_scan_cell.sv
module bsr_scan_cell (
  input  logic tck,
  input  logic rst_an,
  input  logic cap,
  input  logic shf,
  input  logic par_in,
  input  logic scan_in,
  output logic scan_q
);
  logic d;
  logic en;

  always_comb begin
    en = cap | shf;
    d  = scan_q;
    if (cap) begin
      d = par_in;
    end else if (shf) begin
      d = scan_in;
    end
  end

  always_ff @(posedge tck or negedge rst_an) begin
    if (!rst_an) begin
      scan_q <= 1'b0;
    end else if (en) begin
      scan_q <= d;
    end
  end
endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank #(
  parameter int WIDTH = 4
) (
  input  logic             tck,
  input  logic             rst_an,
  input  logic             upd,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = q;
    if (upd) begin
      q_next = d;
    end
  end

  // Falling edge: the pins change half a cycle after the final shift.
  always_ff @(negedge tck or negedge rst_an) begin
    if (!rst_an) begin
      q <= '0;
    end else if (upd) begin
      q <= q_next;
    end
  end
endmodule

// File: rtl/bsr_tdo_stage.sv
module bsr_tdo_stage (
  input  logic tck,
  input  logic rst_an,
  input  logic shf,
  input  logic bit_in,
  output logic tdo
);
  logic tdo_next;

  always_comb begin
    tdo_next = tdo;
    if (shf) begin
      tdo_next = bit_in;
    end
  end

  always_ff @(negedge tck or negedge rst_an) begin
    if (!rst_an) begin
      tdo <= 1'b0;
    end else if (shf) begin
      tdo <= tdo_next;
    end
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               chain_sel,
  input  logic               capture_en,
  input  logic               shift_en,
  input  logic               update_en,
  input  logic               mode_extest,
  input  logic               tdi,
  input  logic [NUM_OUT-1:0] core_out,
  input  logic [NUM_IN-1:0]  pin_in,
  output logic [NUM_OUT-1:0] pin_out,
  output logic               tdo
);
  localparam int NCELL = NUM_IN + NUM_OUT;

  logic             rst_an;
  bsr_ctl_t         ctl;
  bsr_mode_e        mode;
  logic [NCELL-1:0] sr_q;
  logic [NCELL-1:0] par_in;
  logic [NCELL-1:0] scan_in;
  logic [NUM_OUT-1:0] upd_q;

  assign mode = bsr_mode_e'(mode_extest);

  bsr_rst_sync u_rst (
    .clk    (tck),
    .arst_n (rst_n),
    .rst_an (rst_an)
  );

  bsr_ctl_gate u_ctl (
    .chain_sel  (chain_sel),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .ctl        (ctl)
  );

  // Parallel sources: input cells see pins, output cells see the driven pin.
  assign par_in = {pin_out, pin_in};

  generate
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
      if (i == NCELL - 1) begin : g_head
        assign scan_in[i] = tdi;
      end else begin : g_link
        assign scan_in[i] = sr_q[i+1];
      end
      bsr_scan_cell u_cell (
        .tck     (tck),
        .rst_an  (rst_an),
        .cap     (ctl.capture),
        .shf     (ctl.shift),
        .par_in  (par_in[i]),
        .scan_in (scan_in[i]),
        .scan_q  (sr_q[i])
      );
    end
  endgenerate

  bsr_update_bank #(.WIDTH(NUM_OUT)) u_upd (
    .tck    (tck),
    .rst_an (rst_an),
    .upd    (ctl.update),
    .d      (sr_q[NCELL-1:NUM_IN]),
    .q      (upd_q)
  );

  generate
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_pin
      always_comb begin
        if (mode == MODE_DRIVE) begin
          pin_out[j] = upd_q[j];
        end else begin
          pin_out[j] = core_out[j];
        end
      end
    end
  endgenerate

  bsr_tdo_stage u_tdo (
    .tck    (tck),
    .rst_an (rst_an),
    .shf    (ctl.shift),
    .bit_in (sr_q[0]),
    .tdo    (tdo)
  );
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input logic                       tck,
  input logic                       rst_an,
  input logic                       chain_sel,
  input logic                       capture_en,
  input logic                       shift_en,
  input logic                       update_en,
  input logic                       mode_extest,
  input logic                       tdi,
  input logic [NUM_OUT-1:0]         core_out,
  input logic [NUM_IN-1:0]          pin_in,
  input logic [NUM_OUT-1:0]         pin_out,
  input logic                       tdo,
  input logic [NUM_IN+NUM_OUT-1:0]  sr_q,
  input logic [NUM_OUT-1:0]         upd_q
);
  localparam int NC = NUM_IN + NUM_OUT;

  p_observe_pass_r2: assert property (@(posedge tck) disable iff (!rst_an)
    !mode_extest |-> pin_out == core_out);

  p_drive_upd_r3: assert property (@(posedge tck) disable iff (!rst_an)
    mode_extest |-> pin_out == upd_q);

  p_capture_pins_r4: assert property (@(posedge tck) disable iff (!rst_an)
    (chain_sel && capture_en) |=> sr_q[NUM_IN-1:0] == $past(pin_in));

  p_shift_step_r5: assert property (@(posedge tck) disable iff (!rst_an)
    (chain_sel && shift_en && !capture_en) |=> sr_q == {$past(tdi), $past(sr_q[NC-1:1])});

  p_tdo_cell0_r5: assert property (@(posedge tck) disable iff (!rst_an)
    (chain_sel && shift_en && !capture_en) |-> tdo == sr_q[0]);

  p_upd_load_r6: assert property (@(posedge tck) disable iff (!rst_an)
    (chain_sel && update_en) |-> upd_q == sr_q[NC-1:NUM_IN]);

  p_upd_hold_r6: assert property (@(posedge tck) disable iff (!rst_an)
    !(chain_sel && update_en) |-> $stable(upd_q));

  p_idle_freeze_r7: assert property (@(posedge tck) disable iff (!rst_an)
    !chain_sel |=> $stable(sr_q));
endmodule

bind bsr_chain bsr_chain_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .tck         (tck),
  .rst_an      (rst_an),
  .chain_sel   (chain_sel),
  .capture_en  (capture_en),
  .shift_en    (shift_en),
  .update_en   (update_en),
  .mode_extest (mode_extest),
  .tdi         (tdi),
  .core_out    (core_out),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .tdo         (tdo),
  .sr_q        (sr_q),
  .upd_q       (upd_q)
);

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb;
  localparam int NI = 4;
  localparam int NO = 4;

  logic          tck;
  logic          rst_n;
  logic          chain_sel, capture_en, shift_en, update_en, mode_extest, tdi;
  logic [NO-1:0] core_out;
  logic [NI-1:0] pin_in;
  logic [NO-1:0] pin_out;
  logic          tdo;

  int n_chk;
  int n_fail;
  logic done;
  logic [NO-1:0] upd_m;

  // {mode, core, pin, pattern}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 4'hA, 4'h5, 8'h3C},
    {1'b1, 4'h0, 4'hF, 8'hA5},
    {1'b1, 4'hF, 4'h0, 8'h01},
    {1'b0, 4'h3, 4'hC, 8'hFF},
    {1'b1, 4'h7, 4'h9, 8'h0E},
    {1'b0, 4'hE, 4'h1, 8'h96}
  };

  bsr_chain #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .tck (tck), .rst_n (rst_n), .chain_sel (chain_sel), .capture_en (capture_en),
    .shift_en (shift_en), .update_en (update_en), .mode_extest (mode_extest),
    .tdi (tdi), .core_out (core_out), .pin_in (pin_in), .pin_out (pin_out), .tdo (tdo)
  );

  initial begin
    tck = 1'b0;
    forever #4 tck = ~tck;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic to_neg();
    @(negedge tck); #1;
  endtask

  task automatic to_pos();
    @(posedge tck); #1;
  endtask

  task automatic shift_out(input logic [7:0] pat, input logic [7:0] exp,
                           input logic [NO-1:0] pin_exp, input string req);
    capture_en = 1'b0;
    shift_en   = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tdi = pat[k];
      to_neg();
      check(req, {31'd0, tdo}, {31'd0, exp[k]});
      check("R6 pins steady in shift", {28'd0, pin_out}, {28'd0, pin_exp});
      to_pos();
    end
    shift_en = 1'b0;
  endtask

  initial begin
    logic [7:0] cap;
    logic [7:0] last_pat;
    logic       tdo_before;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; chain_sel = 1'b0; capture_en = 1'b0; shift_en = 1'b0;
    update_en = 1'b0; mode_extest = 1'b0; tdi = 1'b0; core_out = '0; pin_in = '0;
    last_pat = '0;
    repeat (3) to_pos();
    check("R1 tdo in reset", {31'd0, tdo}, 32'd0);
    core_out = 4'h9;
    #1 check("R1 observe in reset", {28'd0, pin_out}, 32'h9);
    mode_extest = 1'b1;
    #1 check("R1 drive in reset", {28'd0, pin_out}, 32'h0);
    mode_extest = 1'b0;
    rst_n = 1'b1;
    repeat (3) to_pos();
    upd_m = '0;

    // Table walk: capture, shift out/in, update.
    for (int v = 0; v < 6; v++) begin
      mode_extest = VEC[v][16];
      core_out    = VEC[v][15:12];
      pin_in      = VEC[v][11:8];
      chain_sel   = 1'b1;
      capture_en  = 1'b1;
      cap = {(VEC[v][16] ? upd_m : VEC[v][15:12]), VEC[v][11:8]};
      to_neg();
      to_pos();
      shift_out(VEC[v][7:0], cap, VEC[v][16] ? upd_m : VEC[v][15:12], "R4 R5 capture readback");
      update_en = 1'b1;
      to_neg();
      upd_m = VEC[v][7:4];
      check(VEC[v][16] ? "R3 drive after update" : "R2 observe after update",
            {28'd0, pin_out}, {28'd0, (VEC[v][16] ? upd_m : VEC[v][15:12])});
      to_pos();
      update_en = 1'b0;
      last_pat = VEC[v][7:0];
    end

    // R7: strobes while deselected change nothing.
    mode_extest = 1'b1;
    chain_sel   = 1'b0;
    pin_in      = 4'hF;
    tdo_before  = tdo;
    capture_en  = 1'b1;
    to_neg(); to_pos();
    capture_en = 1'b0;
    shift_en   = 1'b1;
    tdi        = 1'b1;
    for (int k = 0; k < 8; k++) begin
      to_neg();
      check("R7 tdo frozen", {31'd0, tdo}, {31'd0, tdo_before});
      to_pos();
    end
    shift_en  = 1'b0;
    update_en = 1'b1;
    to_neg();
    check("R7 update ignored", {28'd0, pin_out}, {28'd0, upd_m});
    to_pos();
    update_en = 1'b0;
    chain_sel = 1'b1;
    shift_out(8'h00, last_pat, upd_m, "R7 contents kept");

    // R8: capture wins over a simultaneous shift.
    mode_extest = 1'b0;
    core_out    = 4'h6;
    pin_in      = 4'hA;
    capture_en  = 1'b1;
    shift_en    = 1'b1;
    tdi         = 1'b1;
    to_neg(); to_pos();
    shift_out(8'h50, 8'h6A, 4'h6, "R8 capture priority");

    // R2 / R3: update in observe mode, then switch mode.
    update_en = 1'b1;
    to_neg();
    check("R2 observe ignores update stage", {28'd0, pin_out}, 32'h6);
    to_pos();
    update_en   = 1'b0;
    mode_extest = 1'b1;
    #1 check("R3 drive on mode switch", {28'd0, pin_out}, 32'h5);

    // R1: asynchronous clear mid-test.
    rst_n = 1'b0;
    #1 check("R1 async clear of update stage", {28'd0, pin_out}, 32'h0);
    to_pos();
    rst_n = 1'b1;
    repeat (3) to_pos();
    shift_out(8'hFF, 8'h00, 4'h0, "R1 chain cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule